// File: doc/BRIEF.md
# Direct Page and Data Bank Effective Address Generator

This block turns a short operand into a 24-bit effective address for a small accumulator-style processor. It keeps two base registers. The first is an 8-bit data bank value. The second is a 16-bit direct page base, which names the lowest byte of a 256-byte window. A bank-relative request places the data bank value on the upper address byte, above a 16-bit operand. A direct page request adds an 8-bit offset to the page base. The sum is 17 bits wide, so a window based near the top of bank 0 continues into bank 1. It does not wrap.

A request is accepted through a valid/ready handshake. The result appears on the address output together with a one-cycle done pulse. A latency field gives the number of cycles the request took. The control is a three-state machine:
- **ST_IDLE** accepts requests.
- **ST_HIGH** finishes the upper half of a split page addition.
- **ST_EMIT** presents the result.

The transitions are:
- *accept-fast*: ST_IDLE to ST_EMIT, taken for a bank-relative request or a page base whose low byte is zero.
- *accept-split*: ST_IDLE to ST_HIGH, taken for any other direct page request.
- *carry-resolved*: ST_HIGH to ST_EMIT.
- *retire*: ST_EMIT to ST_IDLE.

A single-chip mode input marks a request as restricted to bank 0. A register load that arrives while a request is in flight is held back until that request retires.

Top module: `dpb_addr_gen`

## Requirements
- R1: After reset the bank register is 00h, the page base is 0000h, req_ready is 1, done is 0, sc_err is 0 and addr is 0.
- R2: A bank-relative request (req_mode = 1) yields addr = {bank, req_off[15:0]} with a latency of one cycle.
- R3: A direct page request (req_mode = 0) yields addr[16:0] = page base + req_off[7:0] as a 17-bit sum, with addr[23:17] = 0. The bits req_off[15:8] have no effect.
- R4: When the page base plus offset exceeds FFFFh, the carry sets addr[16], selecting bank 1. A base of FF00h never carries, and a base of FF01h or above can carry.
- R5: Latency is counted from the accepting clock edge to the cycle in which done is high. It is 1 when the request is bank-relative or the base low byte is 00h, and 2 otherwise. The lat output reports that count while done is high.
- R6: req_ready is high only in ST_IDLE. A request offered while the block is busy is not accepted and produces no completion. done lasts exactly one cycle, and addr changes only in a cycle where done is high.
- R7: A load of either register that arrives in the accepting cycle or while a request is in flight does not change that request's address. The load takes effect for the next request.
- R8: sc_err is high only together with done. It is 1 when sc_mode was high at acceptance and either addr[23:16] is nonzero or the bank register is nonzero.
- R9: A load asserted in ST_IDLE without a request is applied at that clock edge and governs the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_mode | input | 1 | Single-chip restriction, sampled when a request is accepted |
| ld_bank | input | 1 | Load strobe for the data bank register |
| ld_bank_val | input | BANK_W | Value for the data bank register |
| ld_dp | input | 1 | Load strobe for the direct page base |
| ld_dp_val | input | DP_W | Value for the direct page base |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_mode | input | 1 | 0 = direct page, 1 = bank-relative |
| req_off | input | DP_W | Operand; direct page uses the low OFF_W bits |
| done | output | 1 | One-cycle completion pulse |
| addr | output | BANK_W+DP_W | Effective address, valid while done is high |
| lat | output | 2 | Cycles the completed request took |
| sc_err | output | 1 | Single-chip violation, valid with done |

## Verification
The bench builds the block with its defaults: an 8-bit bank, a 16-bit page base and an 8-bit page offset. At these widths the page window's top edge lands exactly on the bank 0/1 boundary. That places bases FF00h, FF01h and FFFFh within reach, so the carry and no-carry sides of the straddle can be tested directly. The 8-bit split also exposes both latency paths, selected by the base low byte. Loads are timed into the accepting cycle, the split cycle and the emit cycle, to show they are deferred to the next request.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_EMIT = 2'd2
    } agen_state_e;

    typedef enum logic {
        MODE_DPAGE   = 1'b0,
        MODE_BANKREL = 1'b1
    } agen_mode_e;

    localparam logic [1:0] LAT_FAST  = 2'd1;
    localparam logic [1:0] LAT_SPLIT = 2'd2;

endpackage

// File: rtl/dpb_defreg.sv
// Base register whose loads are parked while a request is in flight
// and committed when that request retires.
module dpb_defreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         commit,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);

    logic [W-1:0] park_val;
    logic         park_vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            park_val <= '0;
            park_vld <= 1'b0;
        end else if (!hold) begin
            if (ld) begin
                q <= ld_val;
            end
        end else if (commit) begin
            // newest load wins over a parked one
            if (ld) begin
                q <= ld_val;
            end else if (park_vld) begin
                q <= park_val;
            end
            park_vld <= 1'b0;
        end else if (ld) begin
            park_val <= ld_val;
            park_vld <= 1'b1;
        end
    end

endmodule

// File: rtl/dpb_fsm.sv
module dpb_fsm
    import dpb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        fast,
    output agen_state_e state,
    output logic        req_ready,
    output logic        accept,
    output logic        hold,
    output logic        calc_hi,
    output logic        emit
);

    agen_state_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = fast ? ST_EMIT : ST_HIGH;   // accept-fast / accept-split
                end
            end
            ST_HIGH: state_nx = ST_EMIT;                   // carry-resolved
            ST_EMIT: state_nx = ST_IDLE;                   // retire
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        calc_hi   = 1'b0;
        emit      = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_HIGH: calc_hi   = 1'b1;
            ST_EMIT: emit      = 1'b1;
            default: req_ready = 1'b0;
        endcase
        accept = req_ready && req_valid;
        hold   = (state != ST_IDLE) || accept;
    end

endmodule

// File: rtl/dpb_datapath.sv
module dpb_datapath
    import dpb_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int DP_W   = 16,
    parameter int OFF_W  = 8,
    localparam int ADDR_W = BANK_W + DP_W,
    localparam int HI_W   = DP_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              calc_hi,
    input  logic              sc_mode,
    input  logic              req_mode,
    input  logic [DP_W-1:0]   req_off,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [DP_W-1:0]   dp_q,
    output logic              fast,
    output logic [ADDR_W-1:0] addr_q,
    output logic [1:0]        lat_q,
    output logic              err_q
);

    logic [OFF_W:0]      lo_q;
    logic                sc_q;
    logic [OFF_W:0]      lo_sum;
    logic [HI_W:0]       hi_sum;
    logic [ADDR_W-1:0]   bank_addr;
    logic [ADDR_W-1:0]   page_fast_addr;
    logic [ADDR_W-1:0]   fast_addr;
    logic [ADDR_W-1:0]   split_addr;
    logic                is_bank;

    function automatic logic err_of(input logic sc,
                                    input logic [ADDR_W-1:0] a,
                                    input logic [BANK_W-1:0] b);
        return sc && ((a[ADDR_W-1:DP_W] != '0) || (b != '0));
    endfunction

    always_comb begin
        is_bank        = (agen_mode_e'(req_mode) == MODE_BANKREL);
        fast           = is_bank || (dp_q[OFF_W-1:0] == '0);
        lo_sum         = {1'b0, dp_q[OFF_W-1:0]} + {1'b0, req_off[OFF_W-1:0]};
        hi_sum         = {1'b0, dp_q[DP_W-1:OFF_W]} + {{HI_W{1'b0}}, lo_q[OFF_W]};
        bank_addr      = {bank_q, req_off};
        // zero low byte: the offset simply replaces it, no adder needed
        page_fast_addr = {{BANK_W{1'b0}}, dp_q[DP_W-1:OFF_W], req_off[OFF_W-1:0]};
        fast_addr      = is_bank ? bank_addr : page_fast_addr;
        split_addr     = {{(BANK_W-1){1'b0}}, hi_sum, lo_q[OFF_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            sc_q   <= 1'b0;
            addr_q <= '0;
            lat_q  <= '0;
            err_q  <= 1'b0;
        end else if (accept) begin
            sc_q  <= sc_mode;
            lo_q  <= lo_sum;
            lat_q <= fast ? LAT_FAST : LAT_SPLIT;
            if (fast) begin
                addr_q <= fast_addr;
                err_q  <= err_of(sc_mode, fast_addr, bank_q);
            end
        end else if (calc_hi) begin
            addr_q <= split_addr;
            err_q  <= err_of(sc_q, split_addr, bank_q);
        end
    end

endmodule

// File: rtl/dpb_addr_gen.sv
module dpb_addr_gen
    import dpb_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int DP_W   = 16,
    parameter int OFF_W  = 8,
    localparam int ADDR_W = BANK_W + DP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_mode,
    input  logic              ld_bank,
    input  logic [BANK_W-1:0] ld_bank_val,
    input  logic              ld_dp,
    input  logic [DP_W-1:0]   ld_dp_val,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_mode,
    input  logic [DP_W-1:0]   req_off,
    output logic              done,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        lat,
    output logic              sc_err
);

    agen_state_e       state;
    logic              accept;
    logic              hold;
    logic              calc_hi;
    logic              emit;
    logic              fast;
    logic [BANK_W-1:0] bank_q;
    logic [DP_W-1:0]   dp_q;
    logic              err_q;

    dpb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .fast      (fast),
        .state     (state),
        .req_ready (req_ready),
        .accept    (accept),
        .hold      (hold),
        .calc_hi   (calc_hi),
        .emit      (emit)
    );

    dpb_defreg #(.W(BANK_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .commit (emit),
        .ld     (ld_bank),
        .ld_val (ld_bank_val),
        .q      (bank_q)
    );

    dpb_defreg #(.W(DP_W)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .commit (emit),
        .ld     (ld_dp),
        .ld_val (ld_dp_val),
        .q      (dp_q)
    );

    dpb_datapath #(.BANK_W(BANK_W), .DP_W(DP_W), .OFF_W(OFF_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .calc_hi  (calc_hi),
        .sc_mode  (sc_mode),
        .req_mode (req_mode),
        .req_off  (req_off),
        .bank_q   (bank_q),
        .dp_q     (dp_q),
        .fast     (fast),
        .addr_q   (addr),
        .lat_q    (lat),
        .err_q    (err_q)
    );

    assign done   = emit;
    assign sc_err = emit && err_q;

endmodule

// File: rtl/dpb_addr_gen_chk.sv
module dpb_addr_gen_chk #(
    parameter int BANK_W = 8,
    parameter int DP_W   = 16,
    localparam int ADDR_W = BANK_W + DP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_mode,
    input logic              done,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        lat,
    input logic              sc_err
);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_addr_only_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr) |-> done);

    p_bank_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode) |=> done);

    p_lat_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == 2'd1 || lat == 2'd2));

    p_split_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat == 2'd2) |-> (addr[ADDR_W-1:DP_W+1] == '0));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_err |-> done);

endmodule

bind dpb_addr_gen dpb_addr_gen_chk #(.BANK_W(BANK_W), .DP_W(DP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mode  (req_mode),
    .done      (done),
    .addr      (addr),
    .lat       (lat),
    .sc_err    (sc_err)
);

// File: tb/sim_dpb_addr_gen.sv
`timescale 1ns/1ps
module sim_dpb_addr_gen;

    localparam int BANK_W = 8;
    localparam int DP_W   = 16;
    localparam int OFF_W  = 8;
    localparam int ADDR_W = BANK_W + DP_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sc_mode = 1'b0;
    logic              ld_bank = 1'b0;
    logic [BANK_W-1:0] ld_bank_val = '0;
    logic              ld_dp = 1'b0;
    logic [DP_W-1:0]   ld_dp_val = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_mode = 1'b0;
    logic [DP_W-1:0]   req_off = '0;
    logic              done;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        lat;
    logic              sc_err;

    always #2.5 clk = ~clk;

    dpb_addr_gen #(.BANK_W(BANK_W), .DP_W(DP_W), .OFF_W(OFF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sc_mode(sc_mode),
        .ld_bank(ld_bank), .ld_bank_val(ld_bank_val),
        .ld_dp(ld_dp), .ld_dp_val(ld_dp_val),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_off(req_off),
        .done(done), .addr(addr), .lat(lat), .sc_err(sc_err)
    );

    typedef struct {
        logic [ADDR_W-1:0] a;
        int                lt;
        bit                er;
        int                t0;
        string             tag;
    } exp_t;

    exp_t sbq[$];
    int   vec = 0;
    int   bad = 0;
    int   cyc = 0;
    logic [BANK_W-1:0] m_bank = '0;
    logic [DP_W-1:0]   m_dp = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every completion
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && done) begin
            vec++;
            if (sbq.size() == 0) begin
                bad++;
                $display("FAIL R6 stray completion actual addr=%h expected no done", addr);
            end else begin
                e = sbq.pop_front();
                if (addr !== e.a || lat !== e.lt[1:0] || sc_err !== e.er || (cyc - e.t0) != e.lt) begin
                    bad++;
                    $display("FAIL %s actual addr=%h lat=%0d err=%0d delay=%0d expected addr=%h lat=%0d err=%0d",
                             e.tag, addr, lat, sc_err, cyc - e.t0, e.a, e.lt, e.er);
                end
            end
        end
    end

    task automatic load_idle(input bit is_dp, input logic [DP_W-1:0] v);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (is_dp) begin ld_dp = 1'b1; ld_dp_val = v; end
        else begin ld_bank = 1'b1; ld_bank_val = v[BANK_W-1:0]; end
        @(negedge clk);
        ld_dp = 1'b0; ld_bank = 1'b0;
        if (is_dp) m_dp = v; else m_bank = v[BANK_W-1:0];
    endtask

    // ld_at: 0 none, 1 in accepting cycle, 2 the cycle after
    task automatic issue(input bit mode, input logic [DP_W-1:0] off, input bit sc,
                         input int ld_at, input bit ld_is_dp, input logic [DP_W-1:0] ld_v,
                         input bit stray, input string tag);
        exp_t e;
        logic [DP_W:0] s;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (mode) e.a = {m_bank, off};
        else begin
            s = {1'b0, m_dp} + {{(DP_W+1-OFF_W){1'b0}}, off[OFF_W-1:0]};
            e.a = {{(BANK_W-1){1'b0}}, s};
        end
        e.lt  = (mode || m_dp[OFF_W-1:0] == '0) ? 1 : 2;
        e.er  = sc && ((e.a[ADDR_W-1:DP_W] != '0) || (m_bank != '0));
        e.t0  = cyc;
        e.tag = tag;
        sbq.push_back(e);
        req_valid = 1'b1; req_mode = mode; req_off = off; sc_mode = sc;
        if (ld_at == 1) begin
            if (ld_is_dp) begin ld_dp = 1'b1; ld_dp_val = ld_v; end
            else begin ld_bank = 1'b1; ld_bank_val = ld_v[BANK_W-1:0]; end
        end
        @(negedge clk);
        req_valid = 1'b0; ld_dp = 1'b0; ld_bank = 1'b0;
        if (ld_at == 2) begin
            if (ld_is_dp) begin ld_dp = 1'b1; ld_dp_val = ld_v; end
            else begin ld_bank = 1'b1; ld_bank_val = ld_v[BANK_W-1:0]; end
        end
        if (stray) begin
            chk(req_ready == 1'b0, "R6 ready low while busy", {31'd0, req_ready}, 32'd0);
            req_valid = 1'b1; req_mode = ~mode; req_off = ~off;
        end
        if (ld_at == 2 || stray) begin
            @(negedge clk);
            ld_dp = 1'b0; ld_bank = 1'b0; req_valid = 1'b0;
        end
        if (ld_at != 0) begin
            if (ld_is_dp) m_dp = ld_v; else m_bank = ld_v[BANK_W-1:0];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        logic [31:0] x;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk(done == 1'b0, "R1 done after reset", {31'd0, done}, 32'd0);
        chk(sc_err == 1'b0, "R1 sc_err after reset", {31'd0, sc_err}, 32'd0);
        chk(addr == '0, "R1 addr after reset", {8'd0, addr}, 32'd0);

        issue(1'b0, 16'h0034, 1'b0, 0, 1'b0, '0, 1'b0, "R1 R3 page base zero");
        issue(1'b1, 16'hBEEF, 1'b0, 0, 1'b0, '0, 1'b0, "R1 R2 bank zero");
        load_idle(1'b0, 16'h005A);
        issue(1'b1, 16'h1234, 1'b0, 0, 1'b0, '0, 1'b0, "R9 R2 bank load idle");
        issue(1'b0, 16'hFF12, 1'b0, 0, 1'b0, '0, 1'b0, "R3 high offset bits ignored");
        load_idle(1'b1, 16'h0123);
        issue(1'b0, 16'h00F0, 1'b0, 0, 1'b0, '0, 1'b0, "R5 R3 split path");
        load_idle(1'b1, 16'h2300);
        issue(1'b0, 16'h0099, 1'b0, 0, 1'b0, '0, 1'b0, "R5 fast page path");
        load_idle(1'b1, 16'hFF10);
        issue(1'b0, 16'h00F5, 1'b0, 0, 1'b0, '0, 1'b0, "R4 straddle into bank 1");
        load_idle(1'b1, 16'hFF00);
        issue(1'b0, 16'h00FF, 1'b0, 0, 1'b0, '0, 1'b0, "R4 base FF00 no carry");
        load_idle(1'b1, 16'hFF01);
        issue(1'b0, 16'h00FF, 1'b0, 0, 1'b0, '0, 1'b0, "R4 base FF01 carries");
        load_idle(1'b1, 16'hFFFF);
        issue(1'b0, 16'h0001, 1'b0, 0, 1'b0, '0, 1'b0, "R4 base FFFF plus one");
        issue(1'b0, 16'h0000, 1'b0, 0, 1'b0, '0, 1'b0, "R4 base FFFF plus zero");

        // R8 single-chip checks
        load_idle(1'b1, 16'h0100);
        issue(1'b0, 16'h0005, 1'b1, 0, 1'b0, '0, 1'b0, "R8 nonzero bank flagged");
        load_idle(1'b0, 16'h0000);
        issue(1'b1, 16'h7777, 1'b1, 0, 1'b0, '0, 1'b0, "R8 bank zero clean");
        load_idle(1'b1, 16'hFF10);
        issue(1'b0, 16'h00F5, 1'b1, 0, 1'b0, '0, 1'b0, "R8 bank 1 address flagged");
        issue(1'b0, 16'h00F5, 1'b0, 0, 1'b0, '0, 1'b0, "R8 mode off no flag");

        // R7 deferred loads
        load_idle(1'b1, 16'h0123);
        issue(1'b0, 16'h0010, 1'b0, 2, 1'b1, 16'h4400, 1'b0, "R7 page load mid split");
        issue(1'b0, 16'h0010, 1'b0, 0, 1'b0, '0, 1'b0, "R7 page load applied next");
        issue(1'b0, 16'h0020, 1'b0, 1, 1'b1, 16'h0081, 1'b0, "R7 page load in accept cycle");
        issue(1'b0, 16'h0020, 1'b0, 0, 1'b0, '0, 1'b0, "R7 accept-cycle load applied");
        issue(1'b1, 16'hA5A5, 1'b0, 2, 1'b0, 16'h00C3, 1'b0, "R7 bank load in emit cycle");
        issue(1'b1, 16'hA5A5, 1'b0, 0, 1'b0, '0, 1'b0, "R7 bank load applied next");

        // R6 requests offered while busy are ignored
        issue(1'b0, 16'h0040, 1'b0, 0, 1'b0, '0, 1'b1, "R6 split with stray request");
        issue(1'b1, 16'h0042, 1'b0, 0, 1'b0, '0, 1'b1, "R6 fast with stray request");

        // mixed patterns
        x = 32'h1357_9BDF;
        for (int i = 0; i < 40; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            if (x[3]) load_idle(1'b1, x[5] ? {x[23:16], 8'h00} : x[23:8]);
            if (x[4]) load_idle(1'b0, {8'h00, x[31:24]});
            issue(x[9], x[31:16], x[12] & x[13], 0, 1'b0, '0, 1'b0, "R3 R5 mixed pattern");
        end

        repeat (6) @(negedge clk);
        chk(sbq.size() == 0, "R6 all completions seen", sbq.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule